// File: doc/BRIEF.md
# Gray-Coded Counter Clock-Domain Crossing

A small free-running counter lives in a source clock domain. Its value is needed in a destination clock domain that has no fixed phase or frequency relation to the source. The source keeps the count in Gray code, so any single increment flips exactly one bit. The Gray value leaves the source straight from a register. Each of its bits is then resynchronized by its own chain of destination-clocked flip-flops.

On the destination side, the resynchronized Gray word is decoded back to binary and registered. The block also provides a one-cycle change strobe and a valid flag. The valid flag rises once the synchronizer chain has been refilled after reset. When bits are sampled while they are changing, the receiver can only see the count one destination cycle late. It can never see a value that mixes the old and new counts. Each domain has its own asynchronous, active-low reset.

Top module: `gray_count_xing`

## Requirements
- R1: When `cnt_en` is high at a rising `src_clk` edge, `src_gray` advances one step. The encoding is gray = bin XOR (bin >> 1), so the order is 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1011, 1001, 1000 and then 0000 again. When `cnt_en` is low, `src_gray` holds its value.
- R2: Every step of `src_gray` changes exactly one bit, including the wrap from 1000 to 0000.
- R3: Each bit of `src_gray` is carried by its own chain of `SYNC_STAGES` destination flip-flops. The default is 2, and 3 is supported. `src_gray` is driven directly by a source register.
- R4: `dst_bin` is the registered prefix-XOR decode of the synchronized Gray word: the top bit is copied, and each lower bit is the XOR of the decoded bit above it and its own Gray bit. After the source stops, `dst_bin` equals the source count within `SYNC_STAGES`+2 destination cycles.
- R5: When the source clock is slower than the destination clock, each successive `dst_bin` value equals the previous value or the previous value plus one, modulo 16.
- R6: `dst_step` is high for exactly those destination cycles in which `dst_bin` differs from its value one cycle earlier.
- R7: `dst_valid` is low while `dst_rst_n` is low and for the first `SYNC_STAGES` destination edges after release. It goes high on edge `SYNC_STAGES`+1 and stays high until the next reset.
- R8: The two resets are separate, asynchronous and active low. `src_rst_n` forces `src_gray` to zero at once. `dst_rst_n` forces `dst_bin`, `dst_step` and `dst_valid` to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source asynchronous reset, active low |
| cnt_en | input | 1 | Counter advance enable (source domain) |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination asynchronous reset, active low |
| src_gray | output | CNT_W | Registered Gray count in the source domain |
| dst_bin | output | CNT_W | Decoded binary count in the destination domain |
| dst_step | output | 1 | One-cycle pulse when `dst_bin` changes |
| dst_valid | output | 1 | Destination pipeline has refilled after reset |

## Verification
`src_gray` is due one source edge after the enable is sampled. The bench samples it 1 ns after each rising `src_clk` edge and compares it with a model count that the same edge updates. `dst_bin` and `dst_step` move together in the same destination cycle, so each destination check compares the current sample with the one taken one cycle earlier. `dst_valid` is checked against the number of rising `dst_clk` edges counted since release. The decode is checked against the model only after the source has stopped and `SYNC_STAGES`+2 or more destination cycles have passed, so the uncertain arrival cycle never decides a result.

// File: rtl/gcx_pkg.sv
package gcx_pkg;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // prefix XOR from the top bit down
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g, input int w);
      logic [31:0] r;
      r = '0;
      r[w-1] = g[w-1];
      for (int i = w - 2; i >= 0; i--) begin
         r[i] = r[i+1] ^ g[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/gcx_src_count.sv
module gcx_src_count #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] gray_q
);
   import gcx_pkg::*;

   logic [CNT_W-1:0] bin_q;
   logic [CNT_W-1:0] bin_nx;
   logic [31:0]      gray_w;

   assign bin_nx = bin_q + 1'b1;
   assign gray_w = bin_to_gray(32'(bin_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else if (en) begin
         bin_q  <= bin_nx;
         gray_q <= gray_w[CNT_W-1:0];
      end
   end

   // R1: a held enable leaves the crossing word untouched
   a_r1_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(gray_q));

   // R2: never more than one bit flips between cycles
   a_r2_one_bit : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/gcx_sync_bit.sv
module gcx_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gcx_dst_decode.sv
module gcx_dst_decode #(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] gray_sync,
   output logic [CNT_W-1:0] bin_q,
   output logic             step_q,
   output logic             valid_q
);
   import gcx_pkg::*;

   localparam int VC_W = $clog2(SYNC_STAGES + 2);

   logic [31:0]      dec_w;
   logic [CNT_W-1:0] bin_nx;
   logic [VC_W-1:0]  fill_q;

   assign dec_w  = gray_to_bin(32'(gray_sync), CNT_W);
   assign bin_nx = dec_w[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         step_q <= 1'b0;
      end else begin
         bin_q  <= bin_nx;
         step_q <= (bin_nx != bin_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (fill_q != VC_W'(SYNC_STAGES)) fill_q <= fill_q + 1'b1;
         if (fill_q == VC_W'(SYNC_STAGES)) valid_q <= 1'b1;
      end
   end

   // R4: re-encoding the output gives back the Gray word seen one edge earlier
   a_r4_decode : assert property (@(posedge clk) disable iff (!rst_n)
      (bin_q ^ (bin_q >> 1)) == $past(gray_sync));

   // R6: strobe marks exactly the cycles where the output moved
   a_r6_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      step_q == (bin_q != $past(bin_q)));

   // R7: valid never drops outside reset
   a_r7_valid_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> valid_q);

endmodule

// File: rtl/gray_count_xing.sv
module gray_count_xing #(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             src_clk,
   input  logic             src_rst_n,
   input  logic             cnt_en,
   input  logic             dst_clk,
   input  logic             dst_rst_n,
   output logic [CNT_W-1:0] src_gray,
   output logic [CNT_W-1:0] dst_bin,
   output logic             dst_step,
   output logic             dst_valid
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("gray_count_xing: CNT_W must be within 2..32");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_bad_depth
      $error("gray_count_xing: SYNC_STAGES must be within 2..8");
   end

   logic [CNT_W-1:0] gray_sync;

   gcx_src_count #(.CNT_W(CNT_W)) u_src (
      .clk    (src_clk),
      .rst_n  (src_rst_n),
      .en     (cnt_en),
      .gray_q (src_gray)
   );

   // R3: one independent chain per Gray bit, fed directly by the register
   for (genvar b = 0; b < CNT_W; b++) begin : g_sync
      gcx_sync_bit #(.STAGES(SYNC_STAGES)) u_bit (
         .clk   (dst_clk),
         .rst_n (dst_rst_n),
         .d     (src_gray[b]),
         .q     (gray_sync[b])
      );
   end

   gcx_dst_decode #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
      .clk       (dst_clk),
      .rst_n     (dst_rst_n),
      .gray_sync (gray_sync),
      .bin_q     (dst_bin),
      .step_q    (dst_step),
      .valid_q   (dst_valid)
   );

endmodule

// File: tb/test_gray_count_xing.sv
`timescale 1ns/1ps
module test_gray_count_xing;
   localparam int W = 4;

   logic src_clk = 1'b0, dst_clk = 1'b0;
   logic src_rst_n = 1'b0, dst_rst_n = 1'b0, cnt_en = 1'b0;
   logic [W-1:0] g2, g3, b2, b3;
   logic s2, s3, v2, v3;
   int checks = 0, errors = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   always #10   dst_clk = ~dst_clk;   // 50 MHz destination
   always #23.5 src_clk = ~src_clk;   // slower, unrelated source

   gray_count_xing #(.CNT_W(W), .SYNC_STAGES(2)) i_gray_count_xing (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .cnt_en(cnt_en),
      .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .src_gray(g2),
      .dst_bin(b2), .dst_step(s2), .dst_valid(v2));

   gray_count_xing #(.CNT_W(W), .SYNC_STAGES(3)) i_gray_count_xing_d3 (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .cnt_en(cnt_en),
      .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .src_gray(g3),
      .dst_bin(b3), .dst_step(s3), .dst_valid(v3));

   function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // source monitor: model count follows the sampled enable
   logic [W-1:0] m_cnt = '0;
   always @(posedge src_clk) begin
      logic [W-1:0] old_g;
      #1;
      if (mon_on && src_rst_n) begin
         old_g = to_gray(m_cnt);
         if (cnt_en) m_cnt = m_cnt + 1'b1;
         chk(g2 == to_gray(m_cnt), "R1 gray step d2", int'(g2), int'(to_gray(m_cnt)));
         chk(g3 == to_gray(m_cnt), "R1 gray step d3", int'(g3), int'(to_gray(m_cnt)));
         if (cnt_en) chk($countones(g2 ^ old_g) == 1, "R2 one bit per step (wrap 1000->0000 included)",
                         $countones(g2 ^ old_g), 1);
      end
   end

   // destination monitor, one state set per instance
   logic [W-1:0] p2 = '0, p3 = '0;
   int k2 = 0, k3 = 0;

   task automatic dst_mon(input logic [W-1:0] b, input logic v, input logic s,
                          inout logic [W-1:0] prev, inout int k, input int stg);
      if (!dst_rst_n) begin
         prev = '0;
         k = 0;
      end else begin
         k++;
         chk(v == (k >= stg + 1), "R7 valid timing", int'(v), int'(k >= stg + 1));
         chk(s == (b != prev), "R6 step strobe", int'(s), int'(b != prev));
         chk(b == prev || b == prev + 1'b1, "R5 no torn value", int'(b), int'(prev));
         prev = b;
      end
   endtask

   always @(posedge dst_clk) begin
      #1;
      if (mon_on) begin
         dst_mon(b2, v2, s2, p2, k2, 2);
         dst_mon(b3, v3, s3, p3, k3, 3);
      end
   end

   task automatic settle_check(input string tag);
      @(negedge src_clk) cnt_en = 1'b0;
      @(posedge src_clk);
      repeat (8) @(negedge dst_clk);
      chk(b2 == m_cnt, {"R4 decode d2 ", tag}, int'(b2), int'(m_cnt));
      chk(b3 == m_cnt, {"R4 decode d3 ", tag}, int'(b3), int'(m_cnt));
      chk(s2 == 1'b0, {"R6 quiet strobe ", tag}, int'(s2), 0);
   endtask

   task automatic run_random(input int n, input int pct);
      for (int i = 0; i < n; i++) begin
         @(negedge src_clk) cnt_en = (($urandom % 100) < pct);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      #5;
      // R8 reset state, with both resets low from time zero
      chk(g2 == '0 && g3 == '0, "R8 src reset", int'(g2), 0);
      chk(b2 == '0 && b3 == '0, "R8 dst reset", int'(b2), 0);
      chk(v2 == 1'b0 && s2 == 1'b0, "R8 valid/step reset", int'(v2), 0);
      mon_on = 1'b1;
      @(negedge dst_clk) dst_rst_n = 1'b1;
      @(negedge src_clk) src_rst_n = 1'b1;

      // directed: long run of enables crosses several wraps
      for (int i = 0; i < 40; i++) @(negedge src_clk) cnt_en = 1'b1;
      settle_check("after burst");

      run_random(1500, 70);
      settle_check("after random 70");
      run_random(800, 20);
      settle_check("after random 20");

      // mid-run asynchronous reset of both domains
      @(negedge dst_clk);
      #3;
      src_rst_n = 1'b0;
      dst_rst_n = 1'b0;
      #1;
      chk(g2 == '0 && g3 == '0, "R8 async src reset", int'(g2), 0);
      chk(b2 == '0 && b3 == '0, "R8 async dst reset", int'(b2), 0);
      chk(v2 == 1'b0 && v3 == 1'b0 && s2 == 1'b0, "R8 async valid/step", int'(v2), 0);
      m_cnt = '0;
      repeat (3) @(negedge dst_clk);
      dst_rst_n = 1'b1;
      @(negedge src_clk) src_rst_n = 1'b1;

      run_random(600, 90);
      settle_check("after reset run");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule